// File: doc/BRIEF.md
# Renaming Reservation-Station Scheduler

This block sits between an in-order instruction front end and two execution units. It holds three add-class reservation stations and two multiply-class stations, along with a 32-entry register file in which every entry has a pending-producer tag. An accepted operation takes the lowest free station of its class. Each source operand is resolved when the operation is accepted. If the register holds a value, the station copies that value. If the register is waiting on a producer, the station records the producer's tag. The destination register's tag is then replaced by the new station's tag. This replacement renames the register, so an accepted operation never waits on a write-after-read or write-after-write hazard.

A station is sent to its execution unit when both of its operands hold values. Each unit is a fixed-latency pipeline that carries the result's tag along with it. The result bus carries one tag and one value per cycle. When more than one unit has a finished result, a fixed-priority arbiter chooses which one drives the bus. Every broadcast does three things at once: waiting stations pick up the value, registers whose tag matches are written and their tags cleared, and the producing station is freed. A read port shows any register's value and pending tag.

Top module: `resv_station_core`

## Requirements
- R1: After reset, register r holds the value r and has tag 0. All stations are free, `cdb_valid` is 0, and `iss_ready` is 1 for both classes.
- R2: Tags 1 to 3 are the add stations (`iss_unit`=0) and tags 4 to 5 are the multiply stations (`iss_unit`=1). `iss_tag` gives the lowest-numbered free station of the requested class. `iss_ready` is 0 when that class has no free station. An operation offered while `iss_ready` is 0 is ignored and renames nothing.
- R3: If a source register has a nonzero tag at acceptance, the station records that tag and waits. `rd_tag` shows a register's pending tag, and tag 0 means the value is present.
- R4: In the cycle after an operation is accepted, the destination register's `rd_tag` equals the `iss_tag` of that operation.
- R5: If a source register's producer broadcasts in the same cycle the consumer is accepted, the consumer takes the broadcast value. It is then ready in the following cycle, exactly as if the value had been present.
- R6: A station is sent to execution only when both operands hold values. For add: `iss_op`=0 gives a+b and `iss_op`=1 gives a-b. For multiply: `iss_op`=0 gives the low 16 bits of a*b and `iss_op`=1 gives the high 16 bits. All arithmetic is modulo 2^16.
- R7: Every broadcast tag belongs to an outstanding station. Every station waiting on that tag takes the value. Every register carrying that tag is written and its tag is cleared.
- R8: A broadcast frees the producing station, and that station can be allocated from the next cycle on.
- R9: When both units finish in the same cycle, the multiply unit drives the bus. The add unit holds its result unchanged and broadcasts it in the next cycle the bus is free.
- R10: An add whose operands are both present at acceptance in cycle c, with its unit idle and the bus uncontested, broadcasts in cycle c+3. The same holds for a multiply, which broadcasts in cycle c+4.
- R11: Once all outstanding work has drained, every register holds the value that executing the accepted operations one by one in acceptance order would give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is offered |
| iss_unit | input | 1 | Class: 0 is add, 1 is multiply |
| iss_op | input | 1 | Operation variant within the class |
| iss_dst | input | 5 | Destination register |
| iss_src_a | input | 5 | First source register |
| iss_src_b | input | 5 | Second source register |
| iss_ready | output | 1 | A station of the offered class is free |
| iss_tag | output | 3 | Tag that the offered operation would receive |
| rd_idx | input | 5 | Register read index |
| rd_value | output | 16 | Value of the indexed register |
| rd_tag | output | 3 | Pending producer tag of the indexed register |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | 3 | Tag of the broadcasting station |
| cdb_data | output | 16 | Broadcast result value |

## Verification
The bench aims at the cycle in which a consumer is accepted while its producer broadcasts. A design that captures the stale tag in that cycle leaves the consumer waiting forever, and the run never drains. It forces both units to finish in the same cycle. A design that drops or overwrites the losing result puts a wrong value on the bus, or never broadcasts that tag at all. It fills one station class and then offers one more operation. A design that accepts the extra operation, or renames its destination anyway, shows a wrong `iss_ready` or a wrong register tag. Long random runs over eight registers then create dense write-after-read and write-after-write chains. A design whose renaming is wrong ends with register values that differ from sequential execution.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int N_ADD  = 3;
    localparam int N_MUL  = 2;
    localparam int N_RS   = N_ADD + N_MUL;
    localparam int TAG_W  = $clog2(N_RS + 1);
    localparam int IDX_W  = $clog2(N_RS);
    localparam int DW     = 16;
    localparam int NREG   = 32;
    localparam int RW     = $clog2(NREG);

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [DW-1:0]    word_t;

    typedef struct packed {
        logic  busy;
        logic  op;
        logic  sent;
        word_t vj;
        word_t vk;
        tag_t  qj;
        tag_t  qk;
    } station_t;

    typedef struct packed {
        station_t [N_RS-1:0]  rs;
        word_t    [NREG-1:0]  rv;
        tag_t     [NREG-1:0]  rt;
    } core_t;
endpackage

// File: rtl/fu_pipe.sv
module fu_pipe #(
    parameter int LAT    = 2,
    parameter bit IS_MUL = 1'b0,
    parameter int DW     = 16,
    parameter int TAG_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic [DW-1:0]    in_a,
    input  logic [DW-1:0]    in_b,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             grant,
    output logic             accept,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic [DW-1:0]    out_data
);
    logic [LAT-1:0]            v_q, v_d;
    logic [LAT-1:0][TAG_W-1:0] t_q, t_d;
    logic [LAT-1:0][DW-1:0]    d_q, d_d;
    logic [DW-1:0]             res;
    logic                      stall;

    generate
        if (IS_MUL) begin : g_mul
            logic [2*DW-1:0] prod;
            assign prod = in_a * in_b;
            assign res  = in_op ? prod[2*DW-1:DW] : prod[DW-1:0];
        end else begin : g_add
            assign res = in_op ? (in_a - in_b) : (in_a + in_b);
        end
    endgenerate

    assign stall     = v_q[LAT-1] && !grant;
    assign accept    = !stall;
    assign out_valid = v_q[LAT-1];
    assign out_tag   = t_q[LAT-1];
    assign out_data  = d_q[LAT-1];

    always_comb begin
        v_d = v_q;
        t_d = t_q;
        d_d = d_q;
        if (!stall) begin
            v_d[0] = in_valid;
            t_d[0] = in_tag;
            d_d[0] = res;
            for (int k = 1; k < LAT; k++) begin
                v_d[k] = v_q[k-1];
                t_d[k] = t_q[k-1];
                d_d[k] = d_q[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            t_q <= '0;
            d_q <= '0;
        end else begin
            v_q <= v_d;
            t_q <= t_d;
            d_q <= d_d;
        end
    end

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !grant |=> out_valid && $stable(out_data) && $stable(out_tag));
endmodule

// File: rtl/cdb_arb.sv
module cdb_arb #(
    parameter int N     = 2,
    parameter int DW    = 16,
    parameter int TAG_W = 3
) (
    input  logic [N-1:0]            req,
    input  logic [N-1:0][TAG_W-1:0] req_tag,
    input  logic [N-1:0][DW-1:0]    req_data,
    output logic [N-1:0]            grant,
    output logic                    bus_valid,
    output logic [TAG_W-1:0]        bus_tag,
    output logic [DW-1:0]           bus_data
);
    always_comb begin
        grant     = '0;
        bus_valid = 1'b0;
        bus_tag   = '0;
        bus_data  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !bus_valid) begin
                grant[i]  = 1'b1;
                bus_valid = 1'b1;
                bus_tag   = req_tag[i];
                bus_data  = req_data[i];
            end
        end
    end
endmodule

// File: rtl/resv_station_core.sv
module resv_station_core
    import rs_pkg::*;
#(
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic             iss_unit,
    input  logic             iss_op,
    input  logic [RW-1:0]    iss_dst,
    input  logic [RW-1:0]    iss_src_a,
    input  logic [RW-1:0]    iss_src_b,
    output logic             iss_ready,
    output logic [TAG_W-1:0] iss_tag,
    input  logic [RW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_value,
    output logic [TAG_W-1:0] rd_tag,
    output logic             cdb_valid,
    output logic [TAG_W-1:0] cdb_tag,
    output logic [DW-1:0]    cdb_data
);
    core_t q, d;

    typedef struct packed {
        logic             ok;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        tag_t  tag;
        word_t val;
    } src_t;

    // lowest station in [lo,hi) that is free (want_free) or ready to send
    function automatic pick_t pick(input core_t c, input int lo, input int hi, input bit want_free);
        pick_t p;
        p = '0;
        for (int i = 0; i < N_RS; i++) begin
            if (i >= lo && i < hi && !p.ok) begin
                if (want_free ? !c.rs[i].busy
                              : (c.rs[i].busy && !c.rs[i].sent && c.rs[i].qj == '0 && c.rs[i].qk == '0)) begin
                    p.ok  = 1'b1;
                    p.idx = IDX_W'(i);
                end
            end
        end
        return p;
    endfunction

    pick_t free_p, add_p, mul_p;
    logic  add_acc, mul_acc;
    logic  add_ov, mul_ov;
    tag_t  add_ot, mul_ot;
    word_t add_od, mul_od;
    logic [1:0] gnt;
    src_t  sa, sb;

    function automatic src_t resolve(input core_t c, input logic [RW-1:0] r,
                                     input logic bv, input tag_t bt, input word_t bd);
        src_t s;
        if (c.rt[r] == '0)                s = '{tag: '0, val: c.rv[r]};
        else if (bv && c.rt[r] == bt)     s = '{tag: '0, val: bd};
        else                              s = '{tag: c.rt[r], val: '0};
        return s;
    endfunction

    always_comb begin
        free_p = pick(q, iss_unit ? N_ADD : 0, iss_unit ? N_RS : N_ADD, 1'b1);
        add_p  = pick(q, 0, N_ADD, 1'b0);
        mul_p  = pick(q, N_ADD, N_RS, 1'b0);
    end

    assign iss_ready = free_p.ok;
    assign iss_tag   = free_p.ok ? TAG_W'(free_p.idx) + TAG_W'(1) : '0;
    assign rd_value  = q.rv[rd_idx];
    assign rd_tag    = q.rt[rd_idx];

    fu_pipe #(.LAT(ADD_LAT), .IS_MUL(1'b0), .DW(DW), .TAG_W(TAG_W)) u_add (
        .clk(clk), .rst_n(rst_n), .in_valid(add_p.ok), .in_op(q.rs[add_p.idx].op),
        .in_a(q.rs[add_p.idx].vj), .in_b(q.rs[add_p.idx].vk),
        .in_tag(TAG_W'(add_p.idx) + TAG_W'(1)), .grant(gnt[1]), .accept(add_acc),
        .out_valid(add_ov), .out_tag(add_ot), .out_data(add_od));

    fu_pipe #(.LAT(MUL_LAT), .IS_MUL(1'b1), .DW(DW), .TAG_W(TAG_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(mul_p.ok), .in_op(q.rs[mul_p.idx].op),
        .in_a(q.rs[mul_p.idx].vj), .in_b(q.rs[mul_p.idx].vk),
        .in_tag(TAG_W'(mul_p.idx) + TAG_W'(1)), .grant(gnt[0]), .accept(mul_acc),
        .out_valid(mul_ov), .out_tag(mul_ot), .out_data(mul_od));

    // index 0 has priority: multiply unit
    cdb_arb #(.N(2), .DW(DW), .TAG_W(TAG_W)) u_arb (
        .req({add_ov, mul_ov}), .req_tag({add_ot, mul_ot}), .req_data({add_od, mul_od}),
        .grant(gnt), .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data));

    always_comb begin
        sa = resolve(q, iss_src_a, cdb_valid, cdb_tag, cdb_data);
        sb = resolve(q, iss_src_b, cdb_valid, cdb_tag, cdb_data);
        d  = q;
        // snoop the broadcast
        if (cdb_valid) begin
            for (int i = 0; i < N_RS; i++) begin
                if (q.rs[i].busy && q.rs[i].qj == cdb_tag) begin
                    d.rs[i].vj = cdb_data;
                    d.rs[i].qj = '0;
                end
                if (q.rs[i].busy && q.rs[i].qk == cdb_tag) begin
                    d.rs[i].vk = cdb_data;
                    d.rs[i].qk = '0;
                end
                if (cdb_tag == TAG_W'(i + 1)) d.rs[i] = '0;
            end
            for (int r = 0; r < NREG; r++) begin
                if (q.rt[r] == cdb_tag) begin
                    d.rv[r] = cdb_data;
                    d.rt[r] = '0;
                end
            end
        end
        // send ready stations
        if (add_p.ok && add_acc) d.rs[add_p.idx].sent = 1'b1;
        if (mul_p.ok && mul_acc) d.rs[mul_p.idx].sent = 1'b1;
        // accept and rename (after snoop so the new tag wins)
        if (iss_valid && free_p.ok) begin
            d.rs[free_p.idx] = '{busy: 1'b1, op: iss_op, sent: 1'b0,
                                 vj: sa.val, vk: sb.val, qj: sa.tag, qk: sb.tag};
            d.rt[iss_dst]    = iss_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.rs <= '0;
            q.rt <= '0;
            for (int r = 0; r < NREG; r++) q.rv[r] <= DW'(r);
        end else begin
            q <= d;
        end
    end

    logic [N_RS:0] busy_by_tag;
    always_comb begin
        busy_by_tag = '0;
        for (int i = 0; i < N_RS; i++) busy_by_tag[i+1] = q.rs[i].busy;
    end

    // R4
    rename_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready |=> q.rt[$past(iss_dst)] == $past(iss_tag));
    // R7
    producer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> cdb_tag != '0 && busy_by_tag[cdb_tag]);
    // R8
    station_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |=> !busy_by_tag[$past(cdb_tag)]);
    // R9
    mul_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_ov |-> cdb_valid && cdb_tag > TAG_W'(N_ADD));
endmodule

// File: tb/resv_station_core_tb.sv
module resv_station_core_tb;
    import rs_pkg::*;
    localparam int CLK_NS  = 10;
    localparam int ADD_LAT = 2;
    localparam int MUL_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0, iss_unit = 1'b0, iss_op = 1'b0;
    logic [RW-1:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0, rd_idx = '0;
    logic iss_ready, cdb_valid;
    logic [TAG_W-1:0] iss_tag, rd_tag, cdb_tag;
    logic [DW-1:0] rd_value, cdb_data;

    resv_station_core #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_dut (.*);

    always #(CLK_NS/2) clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    logic [DW-1:0] gold [NREG];
    bit            mbusy [N_RS+1];
    logic [DW-1:0] expv [N_RS+1];
    int            expcyc [N_RS+1];
    string         expreq [N_RS+1];
    int            last_tag, last_cyc;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] calc(input bit unit, input bit op,
                                           input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [2*DW-1:0] p;
        p = a * b;
        if (unit) return op ? p[2*DW-1:DW] : p[DW-1:0];
        return op ? a - b : a + b;
    endfunction

    task automatic cycle(input bit want, input bit unit, input bit op,
                         input int dst, input int s1, input int s2);
        int ct, et, lo, hi;
        bit cv;
        @(negedge clk);
        cyc++;
        cv = cdb_valid;
        ct = int'(cdb_tag);
        if (cv) begin
            check(ct >= 1 && ct <= N_RS && mbusy[ct], "R7", "broadcast tag outstanding", ct, 0);
            if (ct >= 1 && ct <= N_RS) begin
                check(cdb_data == expv[ct], "R6", "broadcast value", cdb_data, expv[ct]);
                if (expcyc[ct] != 0) begin
                    check(cyc == expcyc[ct], expreq[ct], "broadcast cycle", cyc, expcyc[ct]);
                    expcyc[ct] = 0;
                end
            end
        end
        lo = unit ? N_ADD + 1 : 1;
        hi = unit ? N_RS : N_ADD;
        et = 0;
        for (int t = lo; t <= hi; t++) if (!mbusy[t] && et == 0) et = t;
        iss_valid = want; iss_unit = unit; iss_op = op;
        iss_dst = RW'(dst); iss_src_a = RW'(s1); iss_src_b = RW'(s2);
        #1;
        check(iss_ready == (et != 0), "R8", "iss_ready vs free stations", iss_ready, et != 0);
        if (et != 0) check(int'(iss_tag) == et, "R2", "allocated tag", iss_tag, et);
        if (cv && ct >= 1 && ct <= N_RS) mbusy[ct] = 1'b0;
        if (want && et != 0) begin
            expv[et]  = calc(unit, op, gold[s1], gold[s2]);
            gold[dst] = expv[et];
            mbusy[et] = 1'b1;
            last_tag  = et;
            last_cyc  = cyc;
        end
    endtask

    task automatic peek(input int r, input int exp_tag, input bit chk_val, input string req);
        rd_idx = RW'(r);
        #1;
        check(int'(rd_tag) == exp_tag, req, $sformatf("tag of r%0d", r), rd_tag, exp_tag);
        if (chk_val) check(rd_value == gold[r], req, $sformatf("value of r%0d", r), rd_value, gold[r]);
    endtask

    task automatic drain();
        int n = 0;
        bit any = 1'b1;
        while (any && n < 400) begin
            cycle(0, 0, 0, 0, 0, 0);
            n++;
            any = 1'b0;
            for (int t = 1; t <= N_RS; t++) if (mbusy[t]) any = 1'b1;
        end
        check(!any, "R11", "drain completes", any, 0);
        cycle(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_NS * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        for (int r = 0; r < NREG; r++) gold[r] = DW'(r);
        for (int t = 0; t <= N_RS; t++) begin mbusy[t] = 0; expv[t] = '0; expcyc[t] = 0; expreq[t] = ""; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(cdb_valid == 1'b0, "R1", "cdb idle", cdb_valid, 0);
        iss_unit = 1'b0; #1;
        check(iss_ready && iss_tag == 1, "R1", "add ready, tag 1", iss_tag, 1);
        iss_unit = 1'b1; #1;
        check(iss_ready && iss_tag == 4, "R1", "mul ready, tag 4", iss_tag, 4);
        for (int r = 0; r < NREG; r += 7) peek(r, 0, 1, "R1");

        // R10 latency and R4 rename: r3 = r1 + r2
        cycle(1, 0, 0, 3, 1, 2);
        expcyc[last_tag] = last_cyc + 1 + ADD_LAT; expreq[last_tag] = "R10";
        cycle(0, 0, 0, 0, 0, 0);
        peek(3, 1, 0, "R4");
        drain();
        peek(3, 0, 1, "R7");
        // R10 multiply latency
        cycle(1, 1, 1, 6, 31, 30);
        expcyc[last_tag] = last_cyc + 1 + MUL_LAT; expreq[last_tag] = "R10";
        drain();

        // R9 both units finish together
        cycle(1, 1, 0, 4, 5, 6);
        expcyc[last_tag] = last_cyc + 1 + MUL_LAT; expreq[last_tag] = "R9";
        cycle(1, 0, 1, 5, 9, 2);
        expcyc[last_tag] = last_cyc + 2 + ADD_LAT; expreq[last_tag] = "R9";
        drain();

        // R5 consumer accepted in the producer's broadcast cycle
        cycle(1, 1, 0, 7, 2, 3);
        repeat (MUL_LAT) cycle(0, 0, 0, 0, 0, 0);
        cycle(1, 0, 0, 8, 7, 1);
        expcyc[last_tag] = last_cyc + 1 + ADD_LAT; expreq[last_tag] = "R5";
        drain();
        peek(8, 0, 1, "R5");

        // R2 class full, R3 pending tag visible
        cycle(1, 1, 0, 11, 1, 2);
        cycle(1, 0, 0, 12, 11, 1);
        peek(11, 4, 0, "R3");
        cycle(1, 0, 1, 13, 11, 11);
        cycle(1, 0, 0, 14, 1, 11);
        cycle(1, 0, 0, 20, 1, 1);
        check(iss_ready == 1'b0, "R2", "add class full", iss_ready, 0);
        cycle(0, 0, 0, 0, 0, 0);
        peek(20, 0, 1, "R2");
        drain();

        // R11 random dependency chains
        for (int n = 0; n < 1500; n++) begin
            cycle(($urandom % 4) != 0, $urandom % 2, $urandom % 2,
                  $urandom % 8, $urandom % 8, $urandom % 8);
        end
        drain();
        for (int r = 0; r < NREG; r++) peek(r, 0, 1, "R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule